// File: doc/BRIEF.md
# Crosspoint Packet Buffer with Clock-Domain Crossing

This block is one crosspoint of a buffered crossbar switch. Variable-length packets arrive from one input port as 32-bit words, each marked with start-of-packet and end-of-packet flags. They are stored in a two-port register array whose write port runs on the input clock. An output scheduler drains them through the read port, which runs on an unrelated output clock. The scheduler sees an `eligible` flag while at least one packet is pending. It pops words with a show-ahead handshake. The word that closes a packet comes out with `out_eop` set.

Two things cross between the domains. Each accepted start-of-packet flips a single toggle bit, and that bit passes through a flop chain (three stages by default). The Gray-coded write and read pointers each pass through a chain of the same depth, and only one bit of each changes per step. On the read side, every edge of the synchronized toggle adds one to a pending-packet count. Popping an end-of-packet word subtracts one.

Forwarding is cut-through. The reader may follow the writer word by word inside a packet and stalls whenever it has caught up with the synchronized write pointer. A write attempted while the buffer is full drops the word and raises a sticky overflow flag. Start-of-packet markers must be at least two write cycles apart, and the read clock must be fast enough to see every toggle edge. Real packets are 10 to 375 words long, so this always holds in use.

Top module: `xpoint_pktbuf`

## Requirements
- R1: After reset, `eligible`, `out_valid` and `overflow` are low and the buffer holds no words.
- R2: Accepted words come out on `out_data` in the order they were written, with their data unchanged. `out_eop` is high on, and only on, a word that was written with `in_eop` high.
- R3: A word written while no packet is open is stored only if `in_sop` is high, and it opens a packet unless `in_eop` is also high. Between packets, a word with `in_sop` low is discarded and never reaches the output.
- R4: `eligible` goes high after a start-of-packet is accepted. It stays high until the end-of-packet words of all accepted packets have been popped. Several packets can be pending at once.
- R5: Cut-through: `out_valid` can go high and words can be popped before the end-of-packet word of their packet has been written.
- R6: When every written word has been read, `out_valid` is low even while `eligible` is high. The reader never passes the writer.
- R7: With DEPTH words stored and none read, a further write is dropped and `overflow` goes high. `overflow` stays high until the write-side reset.
- R8: A word is removed only on a read-clock edge where `rd_en` and `out_valid` are both high. While `out_valid` is low, `rd_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side (input port) clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | Input word |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| overflow | output | 1 | Sticky: a write was attempted while full |
| rd_clk | input | 1 | Read-side (output scheduler) clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Scheduler pops the presented word |
| out_valid | output | 1 | A stored word is presented on out_data |
| out_data | output | 32 | Presented word |
| out_eop | output | 1 | Presented word ends its packet |
| eligible | output | 1 | At least one packet is pending |

## Verification
The bench builds the block with DEPTH set to 32 and the synchronizer depth kept at 3. With only 32 words of storage, the full condition and the dropped write can be reached within a few dozen write cycles. The random packets of 3 to 20 words wrap the pointers many times, and several whole packets fit in the buffer at once, so pending counts above one are exercised. The read clock runs faster than the write clock, so the reader regularly catches up inside a packet and the cut-through stall occurs often.

// File: rtl/xpb_pkg.sv
package xpb_pkg;
    typedef enum logic {
        W_IDLE = 1'b0,
        W_PKT  = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_IDLE   = 1'b0,
        R_ACTIVE = 1'b1
    } rd_state_e;
endpackage

// File: rtl/xpb_sync.sv
module xpb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xpb_wr_ctrl.sv
module xpb_wr_ctrl
    import xpb_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic          in_eop,
    input  logic [PW-1:0] rptr_gray_sync,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [PW-1:0] wptr_gray,
    output logic          pkt_tog,
    output logic          overflow
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    wr_state_e     state_q, state_d;
    logic [PW-1:0] wptr_q, wptr_d, rptr_bin, occ;
    logic          full, store_req, tog_d, ovf_d;

    always_comb begin
        rptr_bin[PW-1] = rptr_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            rptr_bin[i] = rptr_bin[i+1] ^ rptr_gray_sync[i];
    end

    assign occ  = wptr_q - rptr_bin;
    assign full = (occ == DEPTH_P);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= W_IDLE;
            wptr_q    <= '0;
            wptr_gray <= '0;
            pkt_tog   <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            state_q   <= state_d;
            wptr_q    <= wptr_d;
            wptr_gray <= wptr_d ^ (wptr_d >> 1);
            pkt_tog   <= tog_d;
            overflow  <= ovf_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        store_req = 1'b0;
        tog_d     = pkt_tog;
        unique case (state_q)
            W_IDLE: begin
                if (in_valid && in_sop) begin
                    store_req = 1'b1;
                    if (!full) tog_d = ~pkt_tog;
                    if (!in_eop) state_d = W_PKT;
                end
            end
            W_PKT: begin
                if (in_valid) begin
                    store_req = 1'b1;
                    if (in_eop) state_d = W_IDLE;
                end
            end
        endcase
        wr_en  = store_req && !full;
        ovf_d  = overflow || (store_req && full);
        wptr_d = wptr_q + (wr_en ? PW'(1) : PW'(0));
    end

    assign wr_addr = wptr_q[AW-1:0];

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_wr_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P);
    assert_no_write_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == DEPTH_P) |=> (wptr_q == $past(wptr_q)));
endmodule

// File: rtl/xpb_rd_ctrl.sv
module xpb_rd_ctrl
    import xpb_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          tog_sync,
    input  logic [PW-1:0] wptr_gray_sync,
    input  logic          word_eop,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rptr_gray,
    output logic          out_valid,
    output logic          eligible
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    rd_state_e     state_q, state_d;
    logic [PW-1:0] rptr_q, rptr_d, wptr_bin, pending_q, pending_d;
    logic          tog_prev, tog_edge, caught_up, pop, pop_eop;

    always_comb begin
        wptr_bin[PW-1] = wptr_gray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            wptr_bin[i] = wptr_bin[i+1] ^ wptr_gray_sync[i];
    end

    assign tog_edge  = tog_sync ^ tog_prev;
    assign caught_up = (rptr_q == wptr_bin);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= R_IDLE;
            rptr_q    <= '0;
            rptr_gray <= '0;
            pending_q <= '0;
            tog_prev  <= 1'b0;
        end else begin
            state_q   <= state_d;
            rptr_q    <= rptr_d;
            rptr_gray <= rptr_d ^ (rptr_d >> 1);
            pending_q <= pending_d;
            tog_prev  <= tog_sync;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        unique case (state_q)
            R_IDLE:   out_valid = 1'b0;
            R_ACTIVE: out_valid = !caught_up;
        endcase
        pop       = out_valid && rd_en;
        pop_eop   = pop && word_eop;
        rptr_d    = rptr_q + (pop ? PW'(1) : PW'(0));
        pending_d = pending_q + (tog_edge ? PW'(1) : PW'(0))
                              - (pop_eop ? PW'(1) : PW'(0));
        state_d   = (pending_d != '0) ? R_ACTIVE : R_IDLE;
    end

    assign eligible = (state_q == R_ACTIVE);
    assign rd_addr  = rptr_q[AW-1:0];

    assert_rd_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_bin - rptr_q) <= DEPTH_P);
    assert_eligible_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eligible) |-> $past(pop_eop));
    assert_eop_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_eop |-> (pending_q != '0));
    assert_pop_moves_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> (rptr_q == $past(rptr_q)));
endmodule

// File: rtl/xpoint_pktbuf.sv
module xpoint_pktbuf #(
    parameter int WORD_W      = 32,
    parameter int DEPTH       = 512,
    parameter int SYNC_STAGES = 3,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_eop,
    output logic              eligible
);
    logic [WORD_W:0] mem [DEPTH];
    logic [WORD_W:0] rd_word;
    logic            wr_en, pkt_tog, tog_sync;
    logic [AW-1:0]   wr_addr, rd_addr;
    logic [PW-1:0]   wptr_gray, rptr_gray, wptr_gray_sync, rptr_gray_sync;

    xpb_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .rptr_gray_sync(rptr_gray_sync), .wr_en(wr_en),
        .wr_addr(wr_addr), .wptr_gray(wptr_gray), .pkt_tog(pkt_tog),
        .overflow(overflow)
    );

    xpb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_tog_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(pkt_tog), .q(tog_sync)
    );
    xpb_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wptr_gray_sync)
    );
    xpb_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rptr_gray_sync)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= {in_eop, in_data};
    end

    assign rd_word = mem[rd_addr];

    xpb_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .tog_sync(tog_sync),
        .wptr_gray_sync(wptr_gray_sync), .word_eop(rd_word[WORD_W]),
        .rd_addr(rd_addr), .rptr_gray(rptr_gray), .out_valid(out_valid),
        .eligible(eligible)
    );

    assign out_data = rd_word[WORD_W-1:0];
    assign out_eop  = out_valid && rd_word[WORD_W];
endmodule

// File: tb/xpoint_pktbuf_tb_top.sv
module xpoint_pktbuf_tb_top;
    localparam int DEPTH = 32;

    logic        wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
    logic        in_valid = 0, in_sop = 0, in_eop = 0, rd_en = 0;
    logic [31:0] in_data = '0;
    logic        overflow, out_valid, out_eop, eligible;
    logic [31:0] out_data;

    int checks = 0, errors = 0, rd_mode = 0, eops_seen = 0, pkts_sent = 0;
    bit done = 0;
    logic [32:0] exp_q [$];

    always #10 wr_clk = ~wr_clk;
    always #8  rd_clk = ~rd_clk;

    xpoint_pktbuf #(.WORD_W(32), .DEPTH(DEPTH), .SYNC_STAGES(3)) dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .overflow(overflow), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data),
        .out_eop(out_eop), .eligible(eligible)
    );

    function automatic logic [31:0] mk_word(int pkt, int idx);
        return {pkt[15:0], idx[15:0]} ^ 32'h5A3C_96E1;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reader: choose rd_en at the falling edge; a pop happens at the next rising edge.
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            case (rd_mode)
                0:       rd_en = 1'b0;
                1:       rd_en = ($urandom_range(0, 2) != 0);
                default: rd_en = 1'b1;
            endcase
            if (rd_en && out_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2/R3 unexpected word", {31'd0, out_eop, out_data}, 64'd0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    check({out_eop, out_data} == e, "R2 data/eop order",
                          {31'd0, out_eop, out_data}, {31'd0, e});
                    if (out_eop) eops_seen++;
                end
            end
        end else rd_en = 1'b0;
    end

    task automatic wr_word(logic [31:0] d, bit s, bit e);
        @(negedge wr_clk);
        in_valid = 1; in_data = d; in_sop = s; in_eop = e;
        @(negedge wr_clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic send_pkt(int len, int gap_max);
        for (int i = 0; i < len; i++) begin
            exp_q.push_back({(i == len - 1), mk_word(pkts_sent, i)});
            wr_word(mk_word(pkts_sent, i), i == 0, i == len - 1);
            repeat ($urandom_range(0, gap_max)) @(negedge wr_clk);
        end
        pkts_sent++;
    endtask

    task automatic do_reset();
        wr_rst_n = 0; rd_rst_n = 0;
        repeat (3) @(negedge wr_clk);
        exp_q.delete();
        eops_seen = 0; pkts_sent = 0;
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (2) @(negedge wr_clk);
    endtask

    task automatic wait_drain();
        for (int t = 0; t < 2000 && exp_q.size() != 0; t++) @(negedge rd_clk);
        repeat (12) @(negedge rd_clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset state
        check(eligible == 0, "R1 eligible", eligible, 0);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(overflow == 0, "R1 overflow", overflow, 0);

        // R3 + R8: stray word between packets is discarded; rd_en alone pops nothing
        rd_mode = 2;
        wr_word(32'hDEAD_BEEF, 0, 1);
        repeat (20) @(negedge rd_clk);
        check(out_valid == 0, "R3 stray word out_valid", out_valid, 0);
        check(eligible == 0, "R3 stray word eligible", eligible, 0);

        // R5: cut-through, packet open and reader idle
        rd_mode = 0;
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back({1'b0, mk_word(pkts_sent, i)});
            wr_word(mk_word(pkts_sent, i), i == 0, 0);
        end
        repeat (10) @(negedge rd_clk);
        check(eligible == 1, "R4 eligible before eop", eligible, 1);
        check(out_valid == 1, "R5 out_valid before eop", out_valid, 1);
        // R6: reader catches up inside the packet and stalls
        rd_mode = 2;
        repeat (12) @(negedge rd_clk);
        check(out_valid == 0, "R6 stall when caught up", out_valid, 0);
        check(eligible == 1, "R6 eligible held while stalled", eligible, 1);
        check(exp_q.size() == 0, "R5 words popped before eop", exp_q.size(), 0);
        exp_q.push_back({1'b1, mk_word(pkts_sent, 3)});
        wr_word(mk_word(pkts_sent, 3), 0, 1);
        pkts_sent++;
        wait_drain();
        check(eligible == 0, "R4 eligible falls after eop", eligible, 0);

        // R4: several packets pending at once
        rd_mode = 0;
        for (int p = 0; p < 3; p++) send_pkt(4, 1);
        repeat (10) @(negedge rd_clk);
        check(eligible == 1, "R4 multiple pending", eligible, 1);
        rd_mode = 1;
        wait_drain();
        check(eligible == 0, "R4 all drained", eligible, 0);
        check(eops_seen == pkts_sent, "R2 eop count", eops_seen, pkts_sent);

        // R2/R5/R6: random packets and random reader
        for (int p = 0; p < 60; p++) begin
            send_pkt($urandom_range(3, 20), 2);
            if ($urandom_range(0, 3) == 0) wr_word($urandom, 0, 0); // R3 stray
            repeat ($urandom_range(0, 4)) @(negedge wr_clk);
        end
        wait_drain();
        check(exp_q.size() == 0, "R2 random drain", exp_q.size(), 0);
        check(eops_seen == pkts_sent, "R2 random eop count", eops_seen, pkts_sent);
        check(eligible == 0, "R4 random idle", eligible, 0);

        // R7: overflow
        rd_mode = 0;
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            exp_q.push_back({1'b0, mk_word(99, i)});
            wr_word(mk_word(99, i), i == 0, 0);
        end
        check(overflow == 0, "R7 no overflow at exactly full", overflow, 0);
        wr_word(32'h0BAD_F00D, 0, 1);
        @(negedge wr_clk);
        check(overflow == 1, "R7 overflow set", overflow, 1);
        rd_mode = 2;
        wait_drain();
        check(overflow == 1, "R7 overflow sticky", overflow, 1);
        check(out_valid == 0, "R7 dropped word not stored", out_valid, 0);
        do_reset();
        check(overflow == 0, "R7 cleared by reset", overflow, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule